// File: doc/BRIEF.md
# Repeated Codeword Message Detector

This block watches the serial bit stream of a receive data link for short repeated codewords that carry a six-bit message. A codeword is sixteen bits long. It starts with eight ones and ends with a zero, and between them sit a zero and the six code bits. One match is not enough to report a message. The same code has to arrive in consecutive, back-to-back codewords a programmable number of times, from one to ten. When that happens, the code is copied into an output register and a sticky flag goes high.

Bits arrive one at a time, each qualified by a strobe on the system clock. A four-bit configuration input sets how many repeats are needed. A one-cycle clear strobe drops the flag. While nothing is aligned, the search slides one bit at a time. Once a codeword has matched, the next window is evaluated on the sixteen-bit boundary right after it.

Top module: `bom_detect`

## Requirements
- R1: A codeword is recognised when the sixteen most recent accepted bits, oldest first, are eight ones, a zero, six code bits and a zero. The first code bit received is the most significant bit of the code.
- R2: The flag rises, and the code is latched, in the cycle after the clock edge that accepts the last bit of the Nth consecutive identical codeword, where N is the effective repeat count. Further identical codewords in the same run do not cause a new detection.
- R3: A repeat count of 0 behaves as 1, and a repeat count above 10 behaves as 10.
- R4: An aligned codeword whose code differs from the previous one restarts the run at one. It is a detection on its own when the effective count is 1.
- R5: An aligned window that is not a codeword ends the run, and the search then slides again one bit at a time.
- R6: After a match, the next codeword is only counted when it starts exactly on the bit that follows. A codeword shifted off that boundary is not part of the run, although a sliding search can pick it up later as the first of a new run.
- R7: The flag stays high until a cycle with the clear strobe high. If a detection happens in the same cycle as a clear, the flag stays high.
- R8: Each new detection overwrites the latched code, even while the flag is already high. The latched code changes at no other time.
- R9: Bits presented while the bit strobe is low are ignored.
- R10: After reset the flag is 0 and the latched code is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_en | input | 1 | Qualifies bit_in for this cycle |
| bit_in | input | 1 | Serial data-link bit |
| rpt_cfg | input | 4 | Number of identical codewords needed for detection |
| flag_clr | input | 1 | Clears the detection flag |
| msg_code | output | 6 | Latched code of the last detection |
| msg_flag | output | 1 | Sticky detection flag |

## Verification
The hardest case to reach is a codeword that shows up one bit off the boundary where the next aligned window is due. In that case the aligned window fails and the run is dropped, and the sliding search then has to pick up the shifted codeword as a new first match. A directed sequence inserts a single extra bit between two identical codewords and checks that detection waits one more codeword. Random traffic mixes repeated codes, noise bursts, idle strobes, clears and changes of the repeat count, and compares every cycle against a bench model.

// File: rtl/bom_detect.sv
module bom_detect #(
  parameter int MAX_RPT = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic       bit_in,
  input  logic [3:0] rpt_cfg,
  input  logic       flag_clr,
  output logic [5:0] msg_code,
  output logic       msg_flag
);
  localparam int FW = 16;
  localparam int CW = 6;
  localparam int PW = $clog2(FW);
  localparam logic [3:0] MAXC = 4'(MAX_RPT);

  logic [FW-1:0] sh;
  logic [PW-1:0] ph;
  logic [3:0]    cnt;
  logic [CW-1:0] last;

  wire [FW-1:0] win  = {sh[FW-2:0], bit_in};
  wire          hit  = (win[FW-1:FW-8] == 8'hFF) && !win[FW-9] && !win[0];
  wire [CW-1:0] code = win[CW:1];
  wire [3:0]    thr  = (rpt_cfg == 4'd0) ? 4'd1 : (rpt_cfg > MAXC) ? MAXC : rpt_cfg;
  wire          eval = bit_en && ((cnt == 4'd0) || (ph == PW'(FW-1)));
  wire          same = (cnt != 4'd0) && (code == last);
  wire          det  = eval && hit && (same ? (cnt + 4'd1 == thr) : (thr == 4'd1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '0;
      ph   <= '0;
      cnt  <= '0;
      last <= '0;
    end else if (bit_en) begin
      sh <= win;
      if (eval) begin
        ph <= '0;
        if (!hit)           cnt <= '0;
        else if (!same)     cnt <= 4'd1;
        else if (cnt < MAXC) cnt <= cnt + 4'd1;
        if (hit) last <= code;
      end else begin
        ph <= ph + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msg_code <= '0;
      msg_flag <= 1'b0;
    end else if (det) begin
      msg_code <= code;
      msg_flag <= 1'b1;
    end else if (flag_clr) begin
      msg_flag <= 1'b0;
    end
  end
endmodule

module bom_detect_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bit_en,
  input logic       flag_clr,
  input logic [5:0] msg_code,
  input logic       msg_flag,
  input logic [3:0] cnt
);
  a_r7_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
    msg_flag && !flag_clr |=> msg_flag);
  a_r7_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr && !bit_en |=> !msg_flag);
  a_r9_rise_needs_bit: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> !$rose(msg_flag));
  a_r8_code_only_on_detect: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(msg_code));
  a_r8_code_change_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en ##1 !$stable(msg_code) |-> msg_flag);
  a_r3_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= 4'd10);
endmodule

bind bom_detect bom_detect_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .flag_clr(flag_clr),
  .msg_code(msg_code), .msg_flag(msg_flag), .cnt(cnt)
);

// File: tb/sim_bom_detect.sv
module sim_bom_detect;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_en = 1'b0;
  logic       bit_in = 1'b0;
  logic [3:0] rpt_cfg = 4'd1;
  logic       flag_clr = 1'b0;
  logic [5:0] msg_code;
  logic       msg_flag;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [15:0] m_sh = '0;
  int          m_cnt = 0, m_ph = 0;
  logic [5:0]  m_last = '0, m_code = '0;
  bit          m_flag = 0;

  always #2.5 clk = ~clk;

  bom_detect u0 (.clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
                 .rpt_cfg(rpt_cfg), .flag_clr(flag_clr),
                 .msg_code(msg_code), .msg_flag(msg_flag));

  function automatic int eff_thr(logic [3:0] r);
    if (r == 0) return 1;
    if (r > 10) return 10;
    return int'(r);
  endfunction

  task automatic chk(string req, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic model_step(bit en, bit b, bit clr);
    bit det = 0;
    logic [15:0] w;
    logic [5:0] c;
    bit ok;
    int th;
    if (en) begin
      w  = {m_sh[14:0], b};
      ok = (w[15:8] == 8'hFF) && (w[7] == 1'b0) && (w[0] == 1'b0);
      c  = w[6:1];
      th = eff_thr(rpt_cfg);
      if (m_cnt == 0 || m_ph == 15) begin
        if (!ok) m_cnt = 0;
        else if (m_cnt == 0 || c != m_last) begin
          m_cnt = 1; m_last = c; det = (th == 1);
        end else begin
          det = (m_cnt + 1 == th);
          if (m_cnt < 10) m_cnt++;
        end
        m_ph = 0;
      end else m_ph++;
      m_sh = w;
      if (det) begin m_flag = 1; m_code = c; end
    end
    if (!det && clr) m_flag = 0;
  endtask

  task automatic cyc(bit en, bit b, bit clr);
    bit_en = en; bit_in = b; flag_clr = clr;
    @(negedge clk);
    model_step(en, b, clr);
    chk("R2 model flag", int'(msg_flag), int'(m_flag));
    chk("R8 model code", int'(msg_code), int'(m_code));
  endtask

  task automatic send_cw(logic [5:0] c, bit clr_last = 0);
    logic [15:0] w = {8'hFF, 1'b0, c, 1'b0};
    for (int i = 15; i >= 0; i--) cyc(1'b1, w[i], (i == 0) ? clr_last : 1'b0);
  endtask

  task automatic resync();
    for (int i = 0; i < 16; i++) cyc(1'b1, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset flag", int'(msg_flag), 0);
    chk("R10 reset code", int'(msg_code), 0);
    rst_n = 1'b1;
    @(negedge clk);

    rpt_cfg = 4'd3;
    send_cw(6'h2A); send_cw(6'h2A);
    chk("R2 two of three", int'(msg_flag), 0);
    send_cw(6'h2A);
    chk("R2 third detects", int'(msg_flag), 1);
    chk("R1 code order", int'(msg_code), 'h2A);
    cyc(1'b0, 1'b0, 1'b1);
    chk("R7 clear", int'(msg_flag), 0);
    send_cw(6'h2A);
    chk("R2 no re-detect in run", int'(msg_flag), 0);

    resync();
    rpt_cfg = 4'd0;
    send_cw(6'h15);
    chk("R3 zero acts as one", int'(msg_flag), 1);
    chk("R3 zero code", int'(msg_code), 'h15);

    resync();
    rpt_cfg = 4'd15;
    for (int k = 0; k < 9; k++) send_cw(6'h07);
    chk("R3 nine of ten", int'(msg_flag), 0);
    send_cw(6'h07);
    chk("R3 clamp ten", int'(msg_flag), 1);

    resync();
    rpt_cfg = 4'd2;
    send_cw(6'h11); send_cw(6'h22);
    chk("R4 new code restarts", int'(msg_flag), 0);
    send_cw(6'h22);
    chk("R4 second of new code", int'(msg_flag), 1);
    chk("R4 code", int'(msg_code), 'h22);

    resync();
    send_cw(6'h33);
    for (int i = 0; i < 16; i++) cyc(1'b1, 1'b0, 1'b0);
    send_cw(6'h33);
    chk("R5 broken run", int'(msg_flag), 0);

    resync();
    send_cw(6'h0C);
    cyc(1'b1, 1'b0, 1'b0);
    send_cw(6'h0C);
    chk("R6 off boundary", int'(msg_flag), 0);
    send_cw(6'h0C);
    chk("R6 resynced pair", int'(msg_flag), 1);

    resync();
    send_cw(6'h3F);
    for (int i = 0; i < 5; i++) cyc(1'b0, 1'b1, 1'b0);
    send_cw(6'h3F);
    chk("R9 idle bits ignored", int'(msg_flag), 1);
    chk("R9 code", int'(msg_code), 'h3F);

    resync();
    rpt_cfg = 4'd1;
    send_cw(6'h05);
    send_cw(6'h09, 1'b1);
    chk("R7 detect beats clear", int'(msg_flag), 1);
    chk("R8 code overwritten", int'(msg_code), 'h09);

    void'($urandom(32'h5EED));
    for (int it = 0; it < 2500; it++) begin
      int sel = int'($urandom_range(0, 99));
      if (sel < 5) rpt_cfg = 4'($urandom_range(0, 15));
      if (sel < 60) send_cw(6'($urandom_range(0, 3)) * 6'd21);
      else if (sel < 80) begin
        int n = int'($urandom_range(1, 20));
        for (int i = 0; i < n; i++) cyc(1'b1, 1'($urandom), ($urandom_range(0, 19) == 0));
      end else if (sel < 92) cyc(1'b0, 1'($urandom), 1'b0);
      else cyc(1'($urandom), 1'($urandom), 1'b1);
    end

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule